// File: doc/BRIEF.md
# Six-State Trapezoidal Commutation Sequencer

This block turns a stream of commutation strobes into gate commands for a three-phase MOSFET bridge that uses block (trapezoidal) drive. It keeps a phase index that walks through six drive states. On each accepted strobe the index moves forward or backward. The index is decoded into one high-side and one low-side command per leg. The high-side commands are active-low, so they suit P-channel devices. Separate run and brake inputs override the table, giving coast (every device off) and brake (every low side on). A PWM enable chops the high-side device of the driven leg.

Each leg has its own guard. A leg that reverses from one device to the other spends a programmable number of core clock cycles with both devices off before the new device turns on. A leg whose target is "off" is released at once. A speed output shows either a once-per-electrical-cycle pulse train (FG) or a square wave at the commutation rate (TACHO).

Top module: `bldc_commutator`

## Requirements
- R1: While reset is asserted, every gate is off (`gate_hi_n_o` = 3'b111, `gate_lo_o` = 3'b000) and `spd_o` is low in FG mode. After reset the phase index is state 1, FG is low, and the dead-time register holds 20.
- R2: In run with PWM enabled and no brake, the settled gates follow the state table. Bit 0 is leg A, bit 1 is leg B and bit 2 is leg C. A high-side device is on when its `gate_hi_n_o` bit is 0; a low-side device is on when its `gate_lo_o` bit is 1. The table, listed as (high leg, low leg), is: state 1 (A,C), state 2 (B,C), state 3 (B,A), state 4 (C,A), state 5 (C,B), state 6 (A,B). The third leg is off.
- R3: A `commute_i` pulse sampled with run=1 and brake=0 advances the state by one: 1→2→…→6→1 when `dir_i`=0, and the reverse order when `dir_i`=1. The gates change two clock edges after the strobe is sampled.
- R4: With `run_i`=0, all gates are off from the next clock edge and `commute_i` has no effect on the state.
- R5: With `run_i`=1 and `brake_i`=1, all high sides are off from the next edge and all low sides turn on, subject to R7. `commute_i` has no effect on the state.
- R6: With `pwm_en_i`=0 in run, the high-side device of the driven leg is off and the low-side leg is unchanged. Setting the enable again turns the same high side back on after one edge.
- R7: A leg whose device changes between high and low is held with both devices off for exactly D cycles, where D is the dead-time register and a value of 0 counts as 1. No wait is added in three cases: when a leg goes to off, when it turns back on the side it last used, and when it has already been off for at least D cycles.
- R8: A cycle with `dead_we_i`=1 loads `dead_val_i` into the dead-time register.
- R9: With `spd_sel_i`=0, `spd_o` goes high one edge after a step into state 1 and low one edge after a step into state 4. Otherwise it holds.
- R10: With `spd_sel_i`=1, `spd_o` falls one edge after each step. It rises again after max(floor(N/2),1) cycles, where N is the number of cycles between that step and the step before it.
- R11: In no leg are the high-side and low-side devices on at the same time, and no leg's low side turns on in the cycle after its high side was on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commute_i | input | 1 | Commutation strobe, one cycle per step |
| run_i | input | 1 | 1 = drive, 0 = coast |
| brake_i | input | 1 | 1 = brake while running |
| dir_i | input | 1 | 0 = forward order, 1 = reverse order |
| pwm_en_i | input | 1 | High-side chop enable |
| spd_sel_i | input | 1 | 0 = FG on spd_o, 1 = TACHO on spd_o |
| dead_we_i | input | 1 | Dead-time register write strobe |
| dead_val_i | input | DEAD_W | Dead-time value in core clock cycles |
| gate_hi_n_o | output | 3 | High-side commands, active low, bit 0 = leg A |
| gate_lo_o | output | 3 | Low-side commands, active high, bit 0 = leg A |
| spd_o | output | 1 | FG or TACHO speed signal |

## Verification
A wrong phase index shows up at the gates two edges after the strobe that causes it, as a high/low leg pair that does not match the table. It also shows on the FG output one edge after the step, if that step is wrongly counted as entering state 1 or 4. A fault in a leg guard's counter shows in the number of both-off cycles during a brake engage or release. The bench counts those cycles sample by sample against the programmed value. A wrong period or half-period register in the speed path changes the length of the TACHO low phase, which is measured for several strobe spacings.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;
    localparam int unsigned NUM_LEGS   = 3;
    localparam int unsigned NUM_STATES = 6;

    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_HI  = 2'd1,
        DRV_LO  = 2'd2
    } drv_e;

    typedef logic [2:0] phase_t;
endpackage

// File: rtl/bldc_phase_seq.sv
module bldc_phase_seq
    import bldc_comm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   commute_i,
    input  logic   run_i,
    input  logic   brake_i,
    input  logic   dir_i,
    output phase_t phase_o,
    output phase_t phase_nxt_o,
    output logic   step_o
);
    localparam phase_t LAST = phase_t'(NUM_STATES - 1);

    typedef struct packed {
        phase_t phase;
    } seq_t;

    seq_t q, d;
    logic step;

    always_comb begin
        d    = q;
        step = commute_i & run_i & ~brake_i;
        if (step) begin
            if (!dir_i) begin
                d.phase = (q.phase == LAST) ? '0 : q.phase + 3'd1;
            end else begin
                d.phase = (q.phase == '0) ? LAST : q.phase - 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign phase_o     = q.phase;
    assign phase_nxt_o = d.phase;
    assign step_o      = step;
endmodule

// File: rtl/bldc_phase_decode.sv
module bldc_phase_decode
    import bldc_comm_pkg::*;
(
    input  phase_t phase_i,
    input  logic   run_i,
    input  logic   brake_i,
    input  logic   pwm_en_i,
    output drv_e   leg_o [NUM_LEGS]
);
    logic [1:0] hi_leg;
    logic [1:0] lo_leg;

    always_comb begin
        case (phase_i)
            3'd0:    begin hi_leg = 2'd0; lo_leg = 2'd2; end
            3'd1:    begin hi_leg = 2'd1; lo_leg = 2'd2; end
            3'd2:    begin hi_leg = 2'd1; lo_leg = 2'd0; end
            3'd3:    begin hi_leg = 2'd2; lo_leg = 2'd0; end
            3'd4:    begin hi_leg = 2'd2; lo_leg = 2'd1; end
            3'd5:    begin hi_leg = 2'd0; lo_leg = 2'd1; end
            default: begin hi_leg = 2'd0; lo_leg = 2'd2; end
        endcase
    end

    always_comb begin
        for (int l = 0; l < NUM_LEGS; l++) begin
            if (!run_i) begin
                leg_o[l] = DRV_OFF;
            end else if (brake_i) begin
                leg_o[l] = DRV_LO;
            end else if (2'(l) == hi_leg) begin
                leg_o[l] = pwm_en_i ? DRV_HI : DRV_OFF;
            end else if (2'(l) == lo_leg) begin
                leg_o[l] = DRV_LO;
            end else begin
                leg_o[l] = DRV_OFF;
            end
        end
    end
endmodule

// File: rtl/bldc_leg_guard.sv
module bldc_leg_guard
    import bldc_comm_pkg::*;
#(
    parameter int unsigned DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  drv_e              tgt_i,
    input  logic [DEAD_W-1:0] dead_i,
    output logic              gate_hi_n_o,
    output logic              gate_lo_o
);
    localparam logic [DEAD_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        drv_e              app;
        drv_e              last;
        logic [DEAD_W-1:0] cnt;
    } leg_t;

    leg_t q, d;
    logic [DEAD_W:0] off_len;
    logic            may_turn_on;

    always_comb begin
        d           = q;
        off_len     = {1'b0, q.cnt} + {{DEAD_W{1'b0}}, 1'b1};
        may_turn_on = (q.last == DRV_OFF) || (q.last == tgt_i) ||
                      (off_len >= {1'b0, dead_i});
        if (q.app != DRV_OFF) begin
            if (tgt_i != q.app) begin
                d.app  = DRV_OFF;
                d.last = q.app;
                d.cnt  = '0;
            end
        end else if (tgt_i != DRV_OFF && may_turn_on) begin
            d.app = tgt_i;
        end else if (q.cnt != CNT_MAX) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{app: DRV_OFF, last: DRV_OFF, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign gate_hi_n_o = (q.app != DRV_HI);
    assign gate_lo_o   = (q.app == DRV_LO);
endmodule

// File: rtl/bldc_speed_out.sv
module bldc_speed_out
    import bldc_comm_pkg::*;
#(
    parameter int unsigned PER_W = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_i,
    input  phase_t phase_nxt_i,
    input  logic   sel_i,
    output logic   spd_o
);
    localparam logic [PER_W-1:0] PER_MAX = '1;
    localparam phase_t FG_SET = 3'd0;
    localparam phase_t FG_CLR = 3'd3;

    typedef struct packed {
        logic             fg;
        logic             tacho;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] half;
    } spd_t;

    spd_t q, d;

    always_comb begin
        d = q;
        if (step_i) begin
            d.tacho = 1'b0;
            d.half  = q.per >> 1;
            d.per   = {{(PER_W-1){1'b0}}, 1'b1};
            if (phase_nxt_i == FG_SET) begin
                d.fg = 1'b1;
            end else if (phase_nxt_i == FG_CLR) begin
                d.fg = 1'b0;
            end
        end else begin
            if (q.per != PER_MAX) begin
                d.per = q.per + 1'b1;
            end
            if (q.per >= q.half) begin
                d.tacho = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign spd_o = sel_i ? q.tacho : q.fg;
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_comm_pkg::*;
#(
    parameter int unsigned DEAD_W   = 8,
    parameter int unsigned DEAD_RST = 20,
    parameter int unsigned PER_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commute_i,
    input  logic                run_i,
    input  logic                brake_i,
    input  logic                dir_i,
    input  logic                pwm_en_i,
    input  logic                spd_sel_i,
    input  logic                dead_we_i,
    input  logic [DEAD_W-1:0]   dead_val_i,
    output logic [NUM_LEGS-1:0] gate_hi_n_o,
    output logic [NUM_LEGS-1:0] gate_lo_o,
    output logic                spd_o
);
    localparam logic [DEAD_W-1:0] DEAD_INIT = DEAD_W'(DEAD_RST);

    typedef struct packed {
        logic [DEAD_W-1:0] dead;
    } cfg_t;

    cfg_t   q, d;
    phase_t phase_idx;
    phase_t phase_nxt;
    logic   step;
    drv_e   leg_tgt [NUM_LEGS];

    always_comb begin
        d = q;
        if (dead_we_i) begin
            d.dead = dead_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{dead: DEAD_INIT};
        end else begin
            q <= d;
        end
    end

    bldc_phase_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .commute_i   (commute_i),
        .run_i       (run_i),
        .brake_i     (brake_i),
        .dir_i       (dir_i),
        .phase_o     (phase_idx),
        .phase_nxt_o (phase_nxt),
        .step_o      (step)
    );

    bldc_phase_decode u_dec (
        .phase_i  (phase_idx),
        .run_i    (run_i),
        .brake_i  (brake_i),
        .pwm_en_i (pwm_en_i),
        .leg_o    (leg_tgt)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        bldc_leg_guard #(.DEAD_W(DEAD_W)) u_guard (
            .clk         (clk),
            .rst_n       (rst_n),
            .tgt_i       (leg_tgt[g]),
            .dead_i      (q.dead),
            .gate_hi_n_o (gate_hi_n_o[g]),
            .gate_lo_o   (gate_lo_o[g])
        );
    end

    bldc_speed_out #(.PER_W(PER_W)) u_spd (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step),
        .phase_nxt_i (phase_nxt),
        .sel_i       (spd_sel_i),
        .spd_o       (spd_o)
    );
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk
    import bldc_comm_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                commute_i,
    input logic                run_i,
    input logic                brake_i,
    input logic [NUM_LEGS-1:0] gate_hi_n_o,
    input logic [NUM_LEGS-1:0] gate_lo_o,
    input phase_t              phase_idx
);
    // R11
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~gate_hi_n_o & gate_lo_o) == '0);

    // R11
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(~gate_hi_n_o) & gate_lo_o) == '0) &&
        (($past(gate_lo_o) & ~gate_hi_n_o) == '0));

    // R2
    single_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gate_hi_n_o));

    // R4
    coast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run_i) |-> (gate_hi_n_o == '1 && gate_lo_o == '0));

    // R5
    brake_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_i && brake_i) |-> gate_hi_n_o == '1);

    // R4 R5
    hold_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || brake_i) |=> $stable(phase_idx));

    // R3
    step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commute_i && run_i && !brake_i) |=> phase_idx != $past(phase_idx));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_idx < 3'd6);
endmodule

bind bldc_commutator bldc_commutator_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commute_i   (commute_i),
    .run_i       (run_i),
    .brake_i     (brake_i),
    .gate_hi_n_o (gate_hi_n_o),
    .gate_lo_o   (gate_lo_o),
    .phase_idx   (phase_idx)
);

// File: tb/bldc_commutator_tb.sv
module bldc_commutator_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       commute_i, run_i, brake_i, dir_i, pwm_en_i, spd_sel_i, dead_we_i;
    logic [7:0] dead_val_i;
    logic [2:0] gate_hi_n_o, gate_lo_o;
    logic       spd_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    int s_exp = 1;
    bit fg_exp = 0;

    always #4 clk = ~clk;

    bldc_commutator u_dut (
        .clk(clk), .rst_n(rst_n), .commute_i(commute_i), .run_i(run_i),
        .brake_i(brake_i), .dir_i(dir_i), .pwm_en_i(pwm_en_i),
        .spd_sel_i(spd_sel_i), .dead_we_i(dead_we_i), .dead_val_i(dead_val_i),
        .gate_hi_n_o(gate_hi_n_o), .gate_lo_o(gate_lo_o), .spd_o(spd_o)
    );

    function automatic int hi_leg(input int s);
        return (s % 6) / 2;
    endfunction

    function automatic int lo_leg(input int s);
        return ((s + 1) / 2 + 1) % 3;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_table(input string req);
        check({req, " high-side"}, int'(gate_hi_n_o), int'(~(3'b001 << hi_leg(s_exp)) & 3'b111));
        check({req, " low-side"}, int'(gate_lo_o), int'(3'b001 << lo_leg(s_exp)));
    endtask

    task automatic pulse;
        commute_i = 1'b1;
        @(negedge clk);
        commute_i = 1'b0;
    endtask

    task automatic step_model;
        if (!dir_i) s_exp = (s_exp == 6) ? 1 : s_exp + 1;
        else        s_exp = (s_exp == 1) ? 6 : s_exp - 1;
        if (s_exp == 1) fg_exp = 1;
        if (s_exp == 4) fg_exp = 0;
    endtask

    task automatic sweep(input bit dir);
        dir_i = dir;
        for (int i = 0; i < 12; i++) begin
            pulse();
            step_model();
            check("R9 fg after step", int'(spd_o), int'(fg_exp));
            repeat (30) @(negedge clk);
            check_table(dir ? "R3 reverse R2" : "R3 forward R2");
        end
    endtask

    task automatic dead_test(input int dval);
        int hl = hi_leg(s_exp);
        int cnt;
        int expd = (dval == 0) ? 1 : dval;
        brake_i = 1'b1;
        @(negedge clk);
        cnt = 0;
        while (gate_lo_o[hl] == 1'b0 && cnt < 300) begin
            if (gate_hi_n_o[hl] == 1'b1) cnt++;
            @(negedge clk);
        end
        check("R7 R5 engage both-off cycles", cnt, expd);
        check("R5 brake gates", int'({gate_hi_n_o, gate_lo_o}), int'(6'b111_111));
        brake_i = 1'b0;
        @(negedge clk);
        cnt = 0;
        while (gate_hi_n_o[hl] == 1'b1 && cnt < 300) begin
            if (gate_lo_o[hl] == 1'b0) cnt++;
            @(negedge clk);
        end
        check("R7 release both-off cycles", cnt, expd);
        repeat (20) @(negedge clk);
        check_table("R7 after release R2");
    endtask

    task automatic tacho_test(input int n);
        int cnt;
        pulse(); step_model();
        repeat (n - 1) @(negedge clk);
        pulse(); step_model();
        cnt = 0;
        while (spd_o == 1'b0 && cnt < 500) begin
            cnt++;
            @(negedge clk);
        end
        check("R10 tacho low length", cnt, (n / 2 < 1) ? 1 : n / 2);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R3 run did not complete");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; commute_i = 0; run_i = 0; brake_i = 0; dir_i = 0;
        pwm_en_i = 1; spd_sel_i = 0; dead_we_i = 0; dead_val_i = '0;
        repeat (3) @(negedge clk);
        check("R1 reset high-side", int'(gate_hi_n_o), 7);
        check("R1 reset low-side", int'(gate_lo_o), 0);
        check("R1 reset spd", int'(spd_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 coast after reset", int'({gate_hi_n_o, gate_lo_o}), int'(6'b111_000));
        run_i = 1'b1;
        repeat (3) @(negedge clk);
        check_table("R1 initial state 1 R2");

        // R1 R7: default dead time of 20 cycles
        dead_test(20);

        sweep(1'b0);
        sweep(1'b1);

        // R6: chop the high side
        dir_i = 1'b0;
        pwm_en_i = 1'b0;
        @(negedge clk);
        check("R6 high side off", int'(gate_hi_n_o), 7);
        check("R6 low side kept", int'(gate_lo_o), int'(3'b001 << lo_leg(s_exp)));
        pwm_en_i = 1'b1;
        @(negedge clk);
        check("R6 R7 same side re-on", int'(gate_hi_n_o), int'(~(3'b001 << hi_leg(s_exp)) & 3'b111));

        // R4: coast, strobe ignored
        run_i = 1'b0;
        @(negedge clk);
        check("R4 coast gates", int'({gate_hi_n_o, gate_lo_o}), int'(6'b111_000));
        pulse();
        repeat (3) @(negedge clk);
        run_i = 1'b1;
        repeat (30) @(negedge clk);
        check_table("R4 state kept through coast");

        // R5: brake, strobe ignored
        brake_i = 1'b1;
        repeat (30) @(negedge clk);
        check("R5 brake settled", int'({gate_hi_n_o, gate_lo_o}), int'(6'b111_111));
        pulse();
        brake_i = 1'b0;
        repeat (30) @(negedge clk);
        check_table("R5 state kept through brake");

        // R7 R8: dead-time sweep
        for (int k = 0; k < 4; k++) begin
            dead_we_i = 1'b1;
            dead_val_i = 8'((k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : 7);
            @(negedge clk);
            dead_we_i = 1'b0;
            dead_test(int'(dead_val_i));
        end

        // R10: tacho spacing sweep
        spd_sel_i = 1'b1;
        tacho_test(3);
        tacho_test(9);
        tacho_test(20);
        tacho_test(41);
        spd_sel_i = 1'b0;
        @(negedge clk);
        check("R9 fg restored", int'(spd_o), int'(fg_exp));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule